// File: doc/BRIEF.md
# Multi-drop UART receiver with address filtering

This block receives asynchronous serial frames on one line for a bus shared by several nodes. A programmable divider sets the oversampling tick from the system clock. Each bit is taken in over 16 ticks in normal mode or over 8 ticks in double-speed mode. The bit value is the majority of the three samples around the middle of the bit. The receiver handles 5 to 9 data bits, sent LSB first, with an optional even or odd parity bit.

Every frame is marked as an address frame or a data frame. With 9 data bits, the ninth bit carries the mark. With 5 to 8 data bits, the first stop bit carries it. While the filter input is high, data frames are dropped before they reach storage, so a node only sees the address frames that can select it. Accepted frames go into a two-entry FIFO together with their address, framing-error and parity-error flags. The consumer pops entries from the head.

Top module: `uart_addr_rx`

## Requirements
- R1: `data_bits` selects 5 to 9 data bits, received LSB first. The word appears right-aligned in `rx_word`, and any bits above the selected length read as zero.
- R2: One oversampling tick occurs every `baud_div`+1 clock cycles. A bit lasts 16 ticks when `double_speed`=0 and 8 ticks when it is 1. Frames sent with a ±1.5% rate offset are still received correctly in both modes.
- R3: A bit value is the majority of the three samples at tick positions mid-1, mid and mid+1 of the bit. A disturbance that corrupts a single sample does not change the received bit.
- R4: A low on the idle line is taken as a start bit only if the majority vote at mid-start is low. A shorter low returns the receiver to idle and writes nothing.
- R5: With 5 to 8 data bits, the first stop bit gives the frame type: 1 means address (`rx_addr`=1) and 0 means data (`rx_addr`=0).
- R6: With 9 data bits, data bit 8 gives the frame type (1 = address). It also appears as `rx_word[8]`.
- R7: While `filter_en`=1, a frame with address flag 0 is never written to the FIFO. While `filter_en`=0, every completed frame is written.
- R8: A first stop bit sampled low sets `rx_ferr` for that entry. With 5 to 8 data bits such a frame is a data frame, so it is dropped while filtering.
- R9: With `parity_en`=1, a parity bit follows the data. `parity_odd`=0 expects an even count of ones over data and parity, and `parity_odd`=1 expects an odd count. `rx_perr` is set on a mismatch. With parity disabled, `rx_perr` is 0.
- R10: The FIFO holds two entries and shows the oldest on the outputs. `rx_valid` is high while it is not empty, and `rd_en` removes the head entry.
- R11: A frame that completes while the FIFO is full and is not being popped is discarded and sets `rx_overrun`. The next pop clears the flag.
- R12: After reset, `rx_valid`=0 and `rx_overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| baud_div | input | 12 | Oversampling tick period minus one, in clock cycles |
| double_speed | input | 1 | 1 selects 8 ticks per bit instead of 16 |
| data_bits | input | 4 | Data length, 5 to 9 |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| filter_en | input | 1 | Drop frames that are not address frames |
| rd_en | input | 1 | Pop the FIFO head |
| rx_valid | output | 1 | FIFO holds at least one entry |
| rx_word | output | 9 | Received word of the head entry |
| rx_addr | output | 1 | Head entry is an address frame |
| rx_ferr | output | 1 | Head entry had a low first stop bit |
| rx_perr | output | 1 | Head entry had a parity mismatch |
| rx_overrun | output | 1 | A frame was lost to a full FIFO |

## Verification
The bench mixes address and data frames in 5-, 7-, 8- and 9-bit modes with filtering on and off. A design that tests the wrong bit for the frame type would either drop address frames or let data frames through. Each speed mode is run at +1.5% and -1.5% rate offset. Wrong sample positions would then read a neighbouring bit and corrupt the word. Short line pulses are injected in two places: a pulse in idle checks that no phantom frame is written, and a pulse inside a bit checks that the single-sample majority vote holds. A frame sent with a low stop bit is followed directly by another frame. A design that treats a line that stays low as a new start bit would lose that following frame. A third frame is sent into a full FIFO to check that it is discarded rather than written over the head entry, and that the overrun flag clears on the next pop.

// File: rtl/uart_addr_rx_pkg.sv
`timescale 1ns/1ps
package uart_addr_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [8:0] word;
        logic       addr;
        logic       ferr;
        logic       perr;
    } rx_frame_t;

endpackage

// File: rtl/uart_baud_tick.sv
`timescale 1ns/1ps
module uart_baud_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_frame_rx.sv
`timescale 1ns/1ps
module uart_frame_rx
    import uart_addr_rx_pkg::*;
#(
    parameter int MAX_BITS = 9,
    parameter int CNT_W    = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  logic      double_speed,
    input  logic [3:0] data_bits,
    input  logic      parity_en,
    input  logic      parity_odd,
    output logic      done,
    output rx_frame_t frame
);
    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [3:0]          bitn;
        logic [2:0]          samp;
        logic [MAX_BITS-1:0] shreg;
        logic                par_bit;
        logic                done;
        rx_frame_t           frm;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic [2:0]       samp_n;
    logic             vote;
    logic             at_vote, at_end;
    logic [CNT_W-1:0] vote_pos, last_pos;
    logic [3:0]       nbits;

    always_comb begin
        if (data_bits < 4'd5)      nbits = 4'd5;
        else if (data_bits > 4'd9) nbits = 4'd9;
        else                       nbits = data_bits;

        vote_pos = double_speed ? CNT_W'(5) : CNT_W'(9);
        last_pos = double_speed ? CNT_W'(7) : CNT_W'(15);

        samp_n  = {r_q.samp[1:0], rxd};
        vote    = (samp_n[0] & samp_n[1]) | (samp_n[0] & samp_n[2]) | (samp_n[1] & samp_n[2]);
        at_vote = (r_q.cnt == vote_pos);
        at_end  = (r_q.cnt == last_pos);

        r_d      = r_q;
        r_d.done = 1'b0;

        if (tick) begin
            r_d.samp = samp_n;
            if (r_q.st != ST_IDLE)
                r_d.cnt = at_end ? '0 : r_q.cnt + 1'b1;

            unique case (r_q.st)
                ST_IDLE: begin
                    if (!rxd && r_q.samp[0]) begin
                        r_d.st  = ST_START;
                        r_d.cnt = CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (at_vote && vote) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end else if (at_end) begin
                        r_d.st    = ST_DATA;
                        r_d.bitn  = '0;
                        r_d.shreg = '0;
                    end
                end
                ST_DATA: begin
                    if (at_vote)
                        r_d.shreg[r_q.bitn] = vote;
                    if (at_end) begin
                        if (r_q.bitn == nbits - 4'd1)
                            r_d.st = parity_en ? ST_PAR : ST_STOP;
                        else
                            r_d.bitn = r_q.bitn + 4'd1;
                    end
                end
                ST_PAR: begin
                    if (at_vote) r_d.par_bit = vote;
                    if (at_end)  r_d.st = ST_STOP;
                end
                ST_STOP: begin
                    if (at_vote) begin
                        r_d.done      = 1'b1;
                        r_d.frm.word  = r_q.shreg;
                        r_d.frm.ferr  = ~vote;
                        r_d.frm.addr  = (nbits == 4'd9) ? r_q.shreg[8] : vote;
                        r_d.frm.perr  = parity_en &&
                                        ((^r_q.shreg ^ r_q.par_bit) != parity_odd);
                        r_d.st        = ST_IDLE;
                        r_d.cnt       = '0;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.samp <= 3'b111;
        end else begin
            r_q <= r_d;
        end
    end

    assign done  = r_q.done;
    assign frame = r_q.frm;
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
    import uart_addr_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_frame_t din,
    input  logic      pop,
    output rx_frame_t dout,
    output logic      not_empty,
    output logic      full,
    output logic      overrun
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_frame_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      wp;
        logic [PTR_W-1:0]      rp;
        logic [CNT_W-1:0]      cnt;
        logic                  ovr;
    } fifo_regs_t;

    fifo_regs_t f_d, f_q;
    logic pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (f_q.cnt == CNT_W'(DEPTH));
        pop_ok  = pop && (f_q.cnt != '0);
        push_ok = push && (!full || pop_ok);

        f_d = f_q;
        if (push_ok) begin
            f_d.mem[f_q.wp] = din;
            f_d.wp          = ptr_inc(f_q.wp);
        end
        if (pop_ok)
            f_d.rp = ptr_inc(f_q.rp);

        if (push_ok && !pop_ok)      f_d.cnt = f_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) f_d.cnt = f_q.cnt - 1'b1;

        if (push && !push_ok) f_d.ovr = 1'b1;
        else if (pop_ok)      f_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign dout      = f_q.mem[f_q.rp];
    assign not_empty = (f_q.cnt != '0);
    assign overrun   = f_q.ovr;
endmodule

// File: rtl/uart_addr_rx.sv
`timescale 1ns/1ps
module uart_addr_rx
    import uart_addr_rx_pkg::*;
#(
    parameter int DIV_W   = 12,
    parameter int FIFO_DP = 2,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             double_speed,
    input  logic [3:0]       data_bits,
    input  logic             parity_en,
    input  logic             parity_odd,
    input  logic             filter_en,
    input  logic             rd_en,
    output logic             rx_valid,
    output logic [8:0]       rx_word,
    output logic             rx_addr,
    output logic             rx_ferr,
    output logic             rx_perr,
    output logic             rx_overrun
);
    logic [SYNC_N-1:0] sync_d, sync_q;
    logic              tick;
    logic              frm_done;
    rx_frame_t         frm;
    logic              push;
    logic              fifo_full;
    rx_frame_t         head;

    always_comb sync_d = {sync_q[SYNC_N-2:0], rxd};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (baud_div),
        .tick  (tick)
    );

    uart_frame_rx u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .rxd          (sync_q[SYNC_N-1]),
        .double_speed (double_speed),
        .data_bits    (data_bits),
        .parity_en    (parity_en),
        .parity_odd   (parity_odd),
        .done         (frm_done),
        .frame        (frm)
    );

    assign push = frm_done && (!filter_en || frm.addr);

    uart_rx_fifo #(.DEPTH(FIFO_DP)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .din       (frm),
        .pop       (rd_en),
        .dout      (head),
        .not_empty (rx_valid),
        .full      (fifo_full),
        .overrun   (rx_overrun)
    );

    assign rx_word = head.word;
    assign rx_addr = head.addr;
    assign rx_ferr = head.ferr;
    assign rx_perr = head.perr;
endmodule

// File: rtl/uart_addr_rx_chk.sv
`timescale 1ns/1ps
module uart_addr_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       push,
    input logic       frm_done,
    input logic       frm_addr,
    input logic       frm_ferr,
    input logic       fifo_full,
    input logic       filter_en,
    input logic [3:0] data_bits,
    input logic       rd_en,
    input logic       rx_valid,
    input logic       rx_overrun
);
    a_r7_filter_passes_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (push && filter_en) |-> frm_addr);

    a_r8_low_stop_is_data: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_ferr && data_bits != 4'd9) |-> !frm_addr);

    a_r11_full_push_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full && !rd_en) |=> rx_overrun);

    a_r10_valid_only_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(push));

    a_r10_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !push) |=> !rx_valid);

    a_r11_overrun_clears_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && rd_en && rx_valid) |=> !rx_overrun);
endmodule

bind uart_addr_rx uart_addr_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .frm_done   (frm_done),
    .frm_addr   (frm.addr),
    .frm_ferr   (frm.ferr),
    .fifo_full  (fifo_full),
    .filter_en  (filter_en),
    .data_bits  (data_bits),
    .rd_en      (rd_en),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun)
);

// File: tb/tb_uart_addr_rx.sv
`timescale 1ns/1ps
module tb_uart_addr_rx;
    localparam int  DIV   = 3;
    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [11:0] baud_div = 12'(DIV);
    logic        double_speed = 1'b0;
    logic [3:0]  data_bits = 4'd8;
    logic        parity_en = 1'b0;
    logic        parity_odd = 1'b0;
    logic        filter_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        rx_valid;
    logic [8:0]  rx_word;
    logic        rx_addr, rx_ferr, rx_perr, rx_overrun;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    uart_addr_rx dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div),
        .double_speed(double_speed), .data_bits(data_bits),
        .parity_en(parity_en), .parity_odd(parity_odd),
        .filter_en(filter_en), .rd_en(rd_en),
        .rx_valid(rx_valid), .rx_word(rx_word), .rx_addr(rx_addr),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_overrun(rx_overrun)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic real bit_ns(input real off);
        int spb;
        spb = double_speed ? 8 : 16;
        return spb * (DIV + 1) * CLK_NS * (1.0 + off);
    endfunction

    // spike_bit >= 0 inverts the line for 6 ns in the middle of that data bit
    task automatic send(input logic [8:0] w, input int nb, input logic stop1,
                        input real off, input logic flip_par, input int spike_bit);
        real bt;
        logic p;
        bt = bit_ns(off);
        p = parity_odd ^ flip_par;
        rxd = 1'b0; #(bt);
        for (int i = 0; i < nb; i++) begin
            p ^= w[i];
            if (i == spike_bit) begin
                rxd = w[i];  #(bt / 2.0);
                rxd = ~w[i]; #6;
                rxd = w[i];  #(bt / 2.0 - 6.0);
            end else begin
                rxd = w[i]; #(bt);
            end
        end
        if (parity_en) begin rxd = p; #(bt); end
        rxd = stop1; #(bt);
        rxd = 1'b1;  #(bt);
        repeat (2) @(posedge clk);
    endtask

    task automatic expect_head(input string tag, input logic [8:0] w, input logic a,
                               input logic fe, input logic pe);
        @(negedge clk);
        check({tag, " valid"}, 32'(rx_valid), 32'd1);
        check({tag, " word"},  32'(rx_word),  32'(w));
        check({tag, " addr"},  32'(rx_addr),  32'(a));
        check({tag, " ferr"},  32'(rx_ferr),  32'(fe));
        check({tag, " perr"},  32'(rx_perr),  32'(pe));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        check({tag, " empty"}, 32'(rx_valid), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12 valid after reset", 32'(rx_valid), 32'd0);
        check("R12 overrun after reset", 32'(rx_overrun), 32'd0);
    endtask

    task automatic t_types_8bit();
        data_bits = 4'd8; filter_en = 1'b0; double_speed = 1'b0;
        send(9'h0A5, 8, 1'b1, 0.0, 1'b0, -1);
        expect_head("R5 R1 8-bit address", 9'h0A5, 1'b1, 1'b0, 1'b0);
        send(9'h03C, 8, 1'b0, 0.0, 1'b0, -1);
        send(9'h0E7, 8, 1'b1, 0.0, 1'b0, -1);
        expect_head("R8 R7 data frame kept unfiltered", 9'h03C, 1'b0, 1'b1, 1'b0);
        expect_head("R8 frame after low stop", 9'h0E7, 1'b1, 1'b0, 1'b0);
        expect_empty("R7 only sent frames");
    endtask

    task automatic t_filter_8bit();
        data_bits = 4'd8; filter_en = 1'b1;
        send(9'h011, 8, 1'b0, 0.0, 1'b0, -1);
        expect_empty("R7 R8 data frame dropped");
        send(9'h042, 8, 1'b1, 0.0, 1'b0, -1);
        expect_head("R7 address frame passes filter", 9'h042, 1'b1, 1'b0, 1'b0);
        filter_en = 1'b0;
    endtask

    task automatic t_nine_bit();
        data_bits = 4'd9; filter_en = 1'b1;
        send(9'h0FF, 9, 1'b1, 0.0, 1'b0, -1);
        expect_empty("R6 R7 9-bit data dropped");
        send(9'h123, 9, 1'b1, 0.0, 1'b0, -1);
        expect_head("R6 9-bit address", 9'h123, 1'b1, 1'b0, 1'b0);
        filter_en = 1'b0;
        send(9'h055, 9, 1'b1, 0.0, 1'b0, -1);
        expect_head("R6 9-bit data unfiltered", 9'h055, 1'b0, 1'b0, 1'b0);
        data_bits = 4'd8;
    endtask

    task automatic t_short_words();
        data_bits = 4'd5;
        send(9'h1FF, 5, 1'b1, 0.0, 1'b0, -1);
        expect_head("R1 5-bit upper zero", 9'h01F, 1'b1, 1'b0, 1'b0);
        data_bits = 4'd7;
        send(9'h0D5, 7, 1'b1, 0.0, 1'b0, -1);
        expect_head("R1 7-bit word", 9'h055, 1'b1, 1'b0, 1'b0);
        data_bits = 4'd8;
    endtask

    task automatic t_parity();
        parity_en = 1'b1; parity_odd = 1'b0;
        send(9'h096, 8, 1'b1, 0.0, 1'b0, -1);
        expect_head("R9 even parity good", 9'h096, 1'b1, 1'b0, 1'b0);
        send(9'h096, 8, 1'b1, 0.0, 1'b1, -1);
        expect_head("R9 even parity bad", 9'h096, 1'b1, 1'b0, 1'b1);
        parity_odd = 1'b1;
        send(9'h031, 8, 1'b1, 0.0, 1'b0, -1);
        expect_head("R9 odd parity good", 9'h031, 1'b1, 1'b0, 1'b0);
        send(9'h031, 8, 1'b1, 0.0, 1'b1, -1);
        expect_head("R9 odd parity bad", 9'h031, 1'b1, 1'b0, 1'b1);
        parity_en = 1'b0; parity_odd = 1'b0;
    endtask

    task automatic t_rate_offset();
        filter_en = 1'b1;
        double_speed = 1'b0;
        send(9'h0B4, 8, 1'b1, 0.015, 1'b0, -1);
        expect_head("R2 normal +1.5%", 9'h0B4, 1'b1, 1'b0, 1'b0);
        send(9'h04B, 8, 1'b1, -0.015, 1'b0, -1);
        expect_head("R2 normal -1.5%", 9'h04B, 1'b1, 1'b0, 1'b0);
        double_speed = 1'b1;
        send(9'h0C3, 8, 1'b1, 0.015, 1'b0, -1);
        expect_head("R2 double +1.5%", 9'h0C3, 1'b1, 1'b0, 1'b0);
        send(9'h066, 8, 1'b0, -0.015, 1'b0, -1);
        expect_empty("R2 R7 double-speed data dropped");
        send(9'h05A, 8, 1'b1, -0.015, 1'b0, -1);
        expect_head("R2 double -1.5%", 9'h05A, 1'b1, 1'b0, 1'b0);
        double_speed = 1'b0; filter_en = 1'b0;
    endtask

    task automatic t_glitch();
        rxd = 1'b0; #12; rxd = 1'b1;
        #(2.0 * bit_ns(0.0));
        expect_empty("R4 start glitch ignored");
        send(9'h081, 8, 1'b1, 0.0, 1'b0, -1);
        expect_head("R4 frame after glitch", 9'h081, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_majority();
        send(9'h000, 8, 1'b1, 0.0, 1'b0, 2);
        expect_head("R3 spike in zero bit", 9'h000, 1'b1, 1'b0, 1'b0);
        send(9'h0FF, 8, 1'b1, 0.0, 1'b0, 5);
        expect_head("R3 spike in one bit", 9'h0FF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_overrun();
        send(9'h001, 8, 1'b1, 0.0, 1'b0, -1);
        send(9'h002, 8, 1'b1, 0.0, 1'b0, -1);
        @(negedge clk);
        check("R11 no overrun at two", 32'(rx_overrun), 32'd0);
        send(9'h003, 8, 1'b1, 0.0, 1'b0, -1);
        @(negedge clk);
        check("R11 overrun set", 32'(rx_overrun), 32'd1);
        expect_head("R10 oldest first", 9'h001, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R11 overrun cleared by pop", 32'(rx_overrun), 32'd0);
        expect_head("R10 R11 second kept, third lost", 9'h002, 1'b1, 1'b0, 1'b0);
        expect_empty("R10 R11 drained");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        t_reset();
        t_types_8bit();
        t_filter_8bit();
        t_nine_bit();
        t_short_words();
        t_parity();
        t_rate_offset();
        t_glitch();
        t_majority();
        t_overrun();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule